// File: doc/BRIEF.md
# Timer Resume Value Calculator

This block works out where a fast free-running timer would be if it had kept counting while it was held stopped. It takes the slow sleep-clock counter value read when the timer stopped and the value read now. It also takes the fast timer's current count, its current overflow count and its wrap period. From these it returns the fast timer value and the overflow count to load on restart. Each fast tick of the result is one cycle of a 32 MHz clock, and each sleep tick is one cycle of a 32.768 kHz clock.

The ratio between the two clocks is not an integer. It is 976.5625, which is exactly 15625/16, and the block applies it in fixed point with round-to-nearest. A fixed restart cost of 75 fast cycles is added to the result. The total is then split into a remainder and a quotient over the programmable period by a one-bit-per-cycle restoring divider. A single-cycle `start` captures every operand. One `done` pulse marks the moment the results are valid, and this comes well inside the 75-cycle restart window.

Top module: `tresume_calc`

## Requirements
- R1: The elapsed sleep-tick count is (slp_now - slp_saved) mod 2^24. When that difference is 0, it is 2^24 (a full counter wrap).
- R2: The scaled count is C = floor((elapsed*15625 + 16*(tmr_now + 75) + 8) / 16). This is elapsed*976.5625 plus tmr_now plus 75, rounded to nearest.
- R3: For a period P in 1..65535, tmr_new equals C mod P.
- R4: ovf_new equals (floor(C / P) + ovf_now) mod 2^20.
- R5: done is high for exactly one cycle. It rises 41 clock edges after the edge that samples start, which is within the 75-cycle window.
- R6: busy is high from the edge that accepts start through the cycle in which done is high. A start pulse seen while busy is high is ignored and does not change the result or its timing.
- R7: After reset, busy, done, tmr_new and ovf_new are all 0.
- R8: All operands are captured on the accepting edge. Changing the inputs while busy is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| slp_now | input | 24 | Sleep counter value read now |
| slp_saved | input | 24 | Sleep counter value read at stop |
| tmr_now | input | 16 | Current fast timer value |
| ovf_now | input | 20 | Current overflow count |
| period | input | 16 | Fast timer wrap period, nonzero |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle strobe: results valid |
| tmr_new | output | 16 | Fast timer value to reload |
| ovf_new | output | 20 | Overflow count to reload |

## Verification
The tick differences are swept over 0, small values, values that straddle the 16-tick rounding step, half range and full range minus one. Each is taken both with and without the sleep counter wrapping between the two readings. This separates the wrap rule and the zero-means-full-wrap case from the rounding term. Periods of 1, 2, 3, 1000, 32768 and 65535 are crossed with fast timer values of 0 and 65535. This separates errors in the remainder from errors in the quotient, and an overflow count near 2^20 exposes the 20-bit wrap. Separate runs scramble the operands in mid-calculation or send a second start, to show that they cannot disturb the result or the 41-edge latency.

// File: rtl/tresume_pkg.sv
package tresume_pkg;

  localparam int SLP_W     = 24;
  localparam int TMR_W     = 16;
  localparam int OVF_W     = 20;
  localparam int ACC_W     = 40;
  localparam int RATIO_NUM = 15625;
  localparam int RATIO_SH  = 4;
  localparam int OVH       = 75;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} tr_state_e;

  // Sleep ticks between two readings; equal readings mean one full wrap.
  function automatic logic [ACC_W-1:0] elapsed_ticks(
      input logic [SLP_W-1:0] now, input logic [SLP_W-1:0] saved);
    logic [SLP_W-1:0] d;
    d = now - saved;
    if (d == '0) return ACC_W'(1) << SLP_W;
    return ACC_W'(d);
  endfunction

  // Round-to-nearest of ticks*RATIO_NUM/2^RATIO_SH plus timer and overhead.
  function automatic logic [ACC_W-1:0] scaled_count(
      input logic [ACC_W-1:0] ticks, input logic [TMR_W-1:0] tmr);
    logic [ACC_W-1:0] acc;
    acc = ticks * ACC_W'(RATIO_NUM);
    acc = acc + ((ACC_W'(tmr) + ACC_W'(OVH)) << RATIO_SH);
    acc = acc + (ACC_W'(1) << (RATIO_SH - 1));
    return acc >> RATIO_SH;
  endfunction

endpackage

// File: rtl/tresume_scale.sv
module tresume_scale
  import tresume_pkg::*;
(
  input  logic [SLP_W-1:0] slp_now,
  input  logic [SLP_W-1:0] slp_saved,
  input  logic [TMR_W-1:0] tmr_now,
  output logic [ACC_W-1:0] ticks,
  output logic [ACC_W-1:0] count
);

  always_comb begin
    ticks = elapsed_ticks(slp_now, slp_saved);
    count = scaled_count(ticks, tmr_now);
  end

endmodule

// File: rtl/tresume_div.sv
module tresume_div #(
  parameter int DVD_W = 40,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             fin,
  output logic [DVD_W-1:0] quo,
  output logic [DVS_W-1:0] rem
);

  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] quo_q;
  logic [DVS_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             fin_q;

  // Per-step events brought out for checking.
  logic [DVS_W:0]   rem_sh;
  logic             step_take;
  logic             last_step;

  assign rem_sh    = {rem_q, quo_q[DVD_W-1]};
  assign step_take = run_q && (rem_sh >= {1'b0, divisor});
  assign last_step = run_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        quo_q <= dividend;
        rem_q <= '0;
        cnt_q <= CNT_W'(DVD_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (step_take) rem_q <= DVS_W'(rem_sh - {1'b0, divisor});
        else           rem_q <= rem_sh[DVS_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], step_take};
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_step) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin = fin_q;
  assign quo = quo_q;
  assign rem = rem_q;

  // R3: the finished remainder is below the divisor
  p_rem_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && divisor != '0) |-> (rem_q < divisor));

  // R5: the step counter never runs out while iterating
  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/tresume_calc.sv
module tresume_calc
  import tresume_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SLP_W-1:0] slp_now,
  input  logic [SLP_W-1:0] slp_saved,
  input  logic [TMR_W-1:0] tmr_now,
  input  logic [OVF_W-1:0] ovf_now,
  input  logic [TMR_W-1:0] period,
  output logic             busy,
  output logic             done,
  output logic [TMR_W-1:0] tmr_new,
  output logic [OVF_W-1:0] ovf_new
);

  tr_state_e        st_q;
  logic [SLP_W-1:0] now_l, saved_l;
  logic [TMR_W-1:0] tmr_l, per_l;
  logic [OVF_W-1:0] ovf_l;

  logic             accept_evt;
  logic             div_go;
  logic             div_fin;
  logic [ACC_W-1:0] ticks, count, div_quo;
  logic [TMR_W-1:0] div_rem;

  assign accept_evt = start && (st_q == ST_IDLE);
  assign div_go     = (st_q == ST_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      now_l   <= '0;
      saved_l <= '0;
      tmr_l   <= '0;
      per_l   <= '0;
      ovf_l   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_evt) st_q <= ST_LOAD;
        ST_LOAD: st_q <= ST_RUN;
        ST_RUN:  if (div_fin) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (accept_evt) begin
        now_l   <= slp_now;
        saved_l <= slp_saved;
        tmr_l   <= tmr_now;
        per_l   <= period;
        ovf_l   <= ovf_now;
      end
    end
  end

  tresume_scale u_scale (
    .slp_now   (now_l),
    .slp_saved (saved_l),
    .tmr_now   (tmr_l),
    .ticks     (ticks),
    .count     (count)
  );

  tresume_div #(.DVD_W(ACC_W), .DVS_W(TMR_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (count),
    .divisor  (per_l),
    .fin      (div_fin),
    .quo      (div_quo),
    .rem      (div_rem)
  );

  assign busy    = (st_q != ST_IDLE);
  assign done    = div_fin;
  assign tmr_new = div_rem;
  assign ovf_new = div_quo[OVF_W-1:0] + ovf_l;

  // R5: done lasts a single cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done only appears while a calculation is in flight
  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R8: captured operands hold steady through the calculation
  p_hold_ops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(now_l) && $stable(saved_l) && $stable(tmr_l)
                         && $stable(per_l) && $stable(ovf_l)));

  // R1: the elapsed tick count is never zero
  p_ticks_nz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ticks != '0));

endmodule

// File: tb/tresume_calc_tb.sv
module tresume_calc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] slp_now = '0, slp_saved = '0;
  logic [15:0] tmr_now = '0, period = 16'd1;
  logic [19:0] ovf_now = '0;
  logic        busy, done;
  logic [15:0] tmr_new;
  logic [19:0] ovf_new;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tresume_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .slp_now(slp_now), .slp_saved(slp_saved), .tmr_now(tmr_now),
    .ovf_now(ovf_now), .period(period),
    .busy(busy), .done(done), .tmr_new(tmr_new), .ovf_new(ovf_new)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  // Independent model: 15625/16 = 976 + 9/16, rounded to nearest.
  task automatic run_op(input longint now, input longint saved, input longint tmr,
                        input longint ovf, input longint per,
                        input bit scramble, input bit poke);
    longint d, c, exp_t, exp_o;
    int n;
    d = (now - saved) & 64'hFFFFFF;
    if (d == 0) d = 64'd16777216;                                   // R1
    c = tmr + 75 + d * 976 + (d * 9 + 8) / 16;                      // R2
    exp_t = c % per;                                                // R3
    exp_o = (c / per + ovf) & 64'hFFFFF;                            // R4
    @(negedge clk);
    slp_now = now[23:0]; slp_saved = saved[23:0]; tmr_now = tmr[15:0];
    ovf_now = ovf[19:0]; period = per[15:0]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin                                             // R8
      slp_now = ~slp_now; slp_saved = slp_saved + 24'd77;
      tmr_now = ~tmr_now; ovf_now = ~ovf_now; period = period ^ 16'h0101;
    end
    n = 0;
    while (!done && n < 200) begin
      start = (poke && n == 5);                                     // R6
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 1) check(busy == 1'b1, "R6 busy", longint'(busy), 1);
    end
    start = 1'b0;
    check(n == 41, "R5 latency", n, 41);
    check(tmr_new == exp_t[15:0], "R3 timer value (R1 R2)", longint'(tmr_new), exp_t);
    check(ovf_new == exp_o[19:0], "R4 overflow count (R1 R2)", longint'(ovf_new), exp_o);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R5 one-cycle done", longint'(done), 0);
    check(busy == 1'b0, "R6 busy clears", longint'(busy), 0);
  endtask

  initial begin
    longint deltas[8] = '{0, 1, 2, 15, 16, 17, 64'h800000, 64'hFFFFFF};
    longint pers[6]   = '{1, 2, 3, 1000, 32768, 65535};
    longint tmrs[2]   = '{0, 65535};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check(busy == 1'b0, "R7 busy", longint'(busy), 0);
    check(done == 1'b0, "R7 done", longint'(done), 0);
    check(tmr_new == '0, "R7 tmr_new", longint'(tmr_new), 0);
    check(ovf_new == '0, "R7 ovf_new", longint'(ovf_new), 0);
    rst_n = 1'b1;
    for (int di = 0; di < 8; di++)
      for (int pi = 0; pi < 6; pi++)
        for (int ti = 0; ti < 2; ti++) begin
          // no wrap between readings, then a wrap across 2^24
          run_op(64'h100 + deltas[di], 64'h100, tmrs[ti], 12345, pers[pi], 1'b0, 1'b0);
          run_op((64'hFFFFF0 + deltas[di]) & 64'hFFFFFF, 64'hFFFFF0, tmrs[ti],
                 64'hFFFF0, pers[pi], 1'b0, 1'b0);
        end
    // R8: scrambled operands mid-run; R6: extra start while busy
    run_op(64'h000010, 64'hFFFF00, 500, 7, 977, 1'b1, 1'b0);
    run_op(64'h123456, 64'h123456, 40000, 64'hFFFFF, 1, 1'b1, 1'b0);
    run_op(64'h000400, 64'h000100, 1234, 99, 3125, 1'b0, 1'b1);
    run_op(64'hABCDEF, 64'h012345, 65535, 64'hFFFFE, 65535, 1'b1, 1'b1);
    finish_run();
  end

endmodule